// File: doc/BRIEF.md
# 128-bit Lane Permute Unit

This block rearranges the lanes of two 128-bit source operands, here called the first source (`rsData`) and the second source (`rtData`), into one 128-bit result. It offers a fixed menu of shuffle patterns. Each pattern has a defined lane mapping, so no general byte-index crossbar is needed. The patterns are:

- interleave of the low halves at byte, halfword or word width;
- word interleave of the high halves;
- packing of even words;
- halfword broadcast;
- doubleword copies;
- a rotation of the three low words.

A 4-bit opcode picks the pattern for each request. The block sits in an execute stage next to a register file. The register indices of both sources and of the destination travel with the data:

- A source index of zero forces that operand to read as zero.
- A destination index of zero turns the request into a no-op write.

The result, its valid flag, its write enable and its destination index are all registered, and appear one clock after the request.

Top module: `lanePermUnit`

## Requirements
- R1: Low interleave at lane width w (opcode 0 = byte, 1 = halfword, 2 = word) takes bits 63:0 of both sources. Result lane 2i is second-source lane i, and result lane 2i+1 is first-source lane i, for i from 0 up to 64/w - 1. Lanes count from the least significant end.
- R2: High word interleave (opcode 3) gives the result words, from word 0 upward: second-source word 2, first-source word 2, second-source word 3, first-source word 3. Word k occupies bits 32k+31:32k.
- R3: Even-word pack (opcode 4) gives the result words, from word 0 upward: second-source word 0, second-source word 2, first-source word 0, first-source word 2.
- R4: Halfword broadcast (opcode 5) copies second-source halfword 0 into all four halfwords of bits 63:0. It copies second-source halfword 4 (bits 79:64) into all four halfwords of bits 127:64.
- R5: Low doubleword copy (opcode 6) yields {first[63:0], second[63:0]}. High doubleword copy (opcode 7) yields {second[127:64], first[127:64]}.
- R6: Three-word rotate (opcode 8) yields the following result words:
  - word 0 = second-source word 1;
  - word 1 = second-source word 2;
  - word 2 = second-source word 0;
  - word 3 = second-source word 3.
- R7: A source whose index is 0 is treated as all zeros, whatever its data input carries.
- R8: A destination index of 0 gives `outWrEn` = 0 with `outValid` = 1. Any other destination index gives `outWrEn` = 1 and echoes the index on `outRdIdx`.
- R9: Each request accepted with `inValid` = 1 gives `outValid` = 1 on the next clock edge. A cycle without a request gives `outValid` = 0 and `outWrEn` = 0 on the next edge.
- R10: An opcode value of 9 to 15 yields a zero result with `outValid` still 1.
- R11: While `rstN` is low, `outValid`, `outWrEn`, `outRdIdx` and `outData` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 4 | Permutation opcode |
| rsIdx | input | 5 | First-source register index |
| rtIdx | input | 5 | Second-source register index |
| rdIdx | input | 5 | Destination register index |
| rsData | input | 128 | First-source data |
| rtData | input | 128 | Second-source data |
| outValid | output | 1 | Result valid |
| outWrEn | output | 1 | Result may be written back |
| outRdIdx | output | 5 | Destination index of the result |
| outData | output | 128 | Permuted result |

## Verification
The control state is only one register deep. An opcode decoded to the wrong strobe, or a stale valid or write-enable bit, shows at the ports on the very next edge:
- a wrong strobe produces a wrongly mapped or zero word in `outData`;
- a stale valid or write-enable bit produces a spurious or missing `outValid` or `outWrEn` pulse.

The source patterns use a distinct value in every byte, so a lane taken from the wrong source or position changes a compared byte. The zero-index cases verify that forcing an operand to zero really replaces the data input.

// File: rtl/lanePermPkg.sv
package lanePermPkg;

  typedef enum logic [3:0] {
    OP_ILV_LB  = 4'd0,
    OP_ILV_LH  = 4'd1,
    OP_ILV_LW  = 4'd2,
    OP_ILV_UW  = 4'd3,
    OP_PACK_EW = 4'd4,
    OP_REP_H   = 4'd5,
    OP_CPY_LD  = 4'd6,
    OP_CPY_UD  = 4'd7,
    OP_ROT_3W  = 4'd8
  } permOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       zeroRs;
    logic       zeroRt;
    logic       selIlvLow;
    logic [1:0] ilvWidth;   // 0 byte, 1 halfword, 2 word
    logic       selIlvUp;
    logic       selPack;
    logic       selRep;
    logic       selCpyLo;
    logic       selCpyUp;
    logic       selRot;
  } permCtrl_t;

endpackage

// File: rtl/lanePermCtrl.sv
module lanePermCtrl
  import lanePermPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       opSel,
  input  logic [IDX_W-1:0] rsIdx,
  input  logic [IDX_W-1:0] rtIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output permCtrl_t        ctrl,
  output logic             outValid,
  output logic             outWrEn,
  output logic [IDX_W-1:0] outRdIdx
);

  always_comb begin
    ctrl        = '0;
    ctrl.load   = inValid;
    ctrl.zeroRs = (rsIdx == '0);
    ctrl.zeroRt = (rtIdx == '0);
    case (opSel)
      OP_ILV_LB:  begin ctrl.selIlvLow = 1'b1; ctrl.ilvWidth = 2'd0; end
      OP_ILV_LH:  begin ctrl.selIlvLow = 1'b1; ctrl.ilvWidth = 2'd1; end
      OP_ILV_LW:  begin ctrl.selIlvLow = 1'b1; ctrl.ilvWidth = 2'd2; end
      OP_ILV_UW:  ctrl.selIlvUp = 1'b1;
      OP_PACK_EW: ctrl.selPack  = 1'b1;
      OP_REP_H:   ctrl.selRep   = 1'b1;
      OP_CPY_LD:  ctrl.selCpyLo = 1'b1;
      OP_CPY_UD:  ctrl.selCpyUp = 1'b1;
      OP_ROT_3W:  ctrl.selRot   = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrEn  <= 1'b0;
      outRdIdx <= '0;
    end else begin
      outValid <= inValid;
      outWrEn  <= inValid && (rdIdx != '0);
      if (inValid) outRdIdx <= rdIdx;
    end
  end

endmodule

// File: rtl/lanePermDatapath.sv
module lanePermDatapath
  import lanePermPkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  permCtrl_t         ctrl,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] outData
);

  localparam int HALF_W    = DATA_W / 2;
  localparam int WD_W      = DATA_W / 4;
  localparam int HW_W      = DATA_W / 8;
  localparam int BYTE_W    = DATA_W / 16;
  localparam int NUM_ILV_W = 3;

  logic [DATA_W-1:0] rsV, rtV;
  assign rsV = ctrl.zeroRs ? '0 : rsData;
  assign rtV = ctrl.zeroRt ? '0 : rtData;

  // low-half interleave, one variant per lane width
  logic [NUM_ILV_W-1:0][DATA_W-1:0] ilvLow;
  for (genvar g = 0; g < NUM_ILV_W; g++) begin : gIlv
    localparam int LW = BYTE_W << g;
    localparam int NL = HALF_W / LW;
    for (genvar i = 0; i < NL; i++) begin : gLane
      assign ilvLow[g][(2*i)*LW +: LW]   = rtV[i*LW +: LW];
      assign ilvLow[g][(2*i+1)*LW +: LW] = rsV[i*LW +: LW];
    end
  end

  logic [DATA_W-1:0] ilvUp, packEw, repH, cpyLo, cpyUp, rot3;
  assign ilvUp  = {rsV[3*WD_W +: WD_W], rtV[3*WD_W +: WD_W],
                   rsV[2*WD_W +: WD_W], rtV[2*WD_W +: WD_W]};
  assign packEw = {rsV[2*WD_W +: WD_W], rsV[0 +: WD_W],
                   rtV[2*WD_W +: WD_W], rtV[0 +: WD_W]};
  assign repH   = {{4{rtV[4*HW_W +: HW_W]}}, {4{rtV[0 +: HW_W]}}};
  assign cpyLo  = {rsV[0 +: HALF_W], rtV[0 +: HALF_W]};
  assign cpyUp  = {rtV[HALF_W +: HALF_W], rsV[HALF_W +: HALF_W]};
  assign rot3   = {rtV[3*WD_W +: WD_W], rtV[0 +: WD_W],
                   rtV[2*WD_W +: WD_W], rtV[WD_W +: WD_W]};

  logic [DATA_W-1:0] ilvSel, result;
  always_comb begin
    case (ctrl.ilvWidth)
      2'd0:    ilvSel = ilvLow[0];
      2'd1:    ilvSel = ilvLow[1];
      default: ilvSel = ilvLow[2];
    endcase
  end

  always_comb begin
    if (ctrl.selIlvLow)     result = ilvSel;
    else if (ctrl.selIlvUp) result = ilvUp;
    else if (ctrl.selPack)  result = packEw;
    else if (ctrl.selRep)   result = repH;
    else if (ctrl.selCpyLo) result = cpyLo;
    else if (ctrl.selCpyUp) result = cpyUp;
    else if (ctrl.selRot)   result = rot3;
    else                    result = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outData <= '0;
    else if (ctrl.load) outData <= result;
  end

endmodule

// File: rtl/lanePermUnit.sv
module lanePermUnit
  import lanePermPkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opSel,
  input  logic [IDX_W-1:0]  rsIdx,
  input  logic [IDX_W-1:0]  rtIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic              outValid,
  output logic              outWrEn,
  output logic [IDX_W-1:0]  outRdIdx,
  output logic [DATA_W-1:0] outData
);

  permCtrl_t ctrl;

  lanePermCtrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .rdIdx(rdIdx), .ctrl(ctrl),
    .outValid(outValid), .outWrEn(outWrEn), .outRdIdx(outRdIdx)
  );

  lanePermDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .rsData(rsData), .rtData(rtData), .outData(outData)
  );

endmodule

// File: rtl/lanePermChk.sv
module lanePermChk #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opSel,
  input logic [IDX_W-1:0]  rsIdx,
  input logic [IDX_W-1:0]  rtIdx,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rsData,
  input logic [DATA_W-1:0] rtData,
  input logic              outValid,
  input logic              outWrEn,
  input logic [IDX_W-1:0]  outRdIdx,
  input logic [DATA_W-1:0] outData
);

  localparam int HALF_W = DATA_W / 2;
  localparam int WD_W   = DATA_W / 4;

  // R9
  req_gives_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  idle_gives_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !outWrEn));

  // R8
  null_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rdIdx == '0) |=> (outValid && !outWrEn));

  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel > 4'd8) |=> (outData == '0));

  // R5
  copy_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd6 && rsIdx != '0 && rtIdx != '0) |=>
    (outData == {$past(rsData[HALF_W-1:0]), $past(rtData[HALF_W-1:0])}));

  // R6
  rotate_top_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd8 && rtIdx != '0) |=>
    (outData[DATA_W-1 -: WD_W] == $past(rtData[DATA_W-1 -: WD_W])));

  // R7
  zero_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd5 && rtIdx == '0) |=> (outData == '0));

endmodule

bind lanePermUnit lanePermChk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (.*);

// File: tb/sim_lanePermUnit.sv
`timescale 1ns/1ps
module sim_lanePermUnit;

  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [3:0]    opSel = '0;
  logic [4:0]    rsIdx = '0, rtIdx = '0, rdIdx = '0;
  logic [DW-1:0] rsData = '0, rtData = '0;
  logic          outValid, outWrEn;
  logic [4:0]    outRdIdx;
  logic [DW-1:0] outData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lanePermUnit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .rdIdx(rdIdx),
    .rsData(rsData), .rtData(rtData),
    .outValid(outValid), .outWrEn(outWrEn), .outRdIdx(outRdIdx), .outData(outData)
  );

  localparam logic [DW-1:0] PA = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
  localparam logic [DW-1:0] PB = 128'h11223344_55667788_99AABBCC_DDEEFF01;

  function automatic logic [31:0] wd(input logic [DW-1:0] v, input int k);
    return v[32*k +: 32];
  endfunction

  function automatic logic [DW-1:0] refIlv(input logic [DW-1:0] s, input logic [DW-1:0] t, input int w);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < 64 / w; i++) begin
      for (int b = 0; b < w; b++) begin
        r[2*i*w + b]     = t[i*w + b];
        r[(2*i+1)*w + b] = s[i*w + b];
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] refOp(input logic [3:0] op, input logic [DW-1:0] s, input logic [DW-1:0] t);
    case (op)
      4'd0: return refIlv(s, t, 8);
      4'd1: return refIlv(s, t, 16);
      4'd2: return refIlv(s, t, 32);
      4'd3: return {wd(s,3), wd(t,3), wd(s,2), wd(t,2)};
      4'd4: return {wd(s,2), wd(s,0), wd(t,2), wd(t,0)};
      4'd5: return {{4{t[79:64]}}, {4{t[15:0]}}};
      4'd6: return {s[63:0], t[63:0]};
      4'd7: return {t[127:64], s[127:64]};
      4'd8: return {wd(t,3), wd(t,0), wd(t,2), wd(t,1)};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, result sampled 1 ns after the capturing edge
  task automatic runOp(input string req, input logic [3:0] op, input logic [4:0] si,
                       input logic [4:0] ti, input logic [4:0] di,
                       input logic [DW-1:0] s, input logic [DW-1:0] t);
    logic [DW-1:0] exp;
    exp = refOp(op, (si == 0) ? '0 : s, (ti == 0) ? '0 : t);
    @(negedge clk);
    inValid = 1'b1; opSel = op; rsIdx = si; rtIdx = ti; rdIdx = di;
    rsData = s; rtData = t;
    @(posedge clk); #1;
    chk(outData == exp, req, outData, exp);
    chk(outValid == 1'b1, {req, " valid"}, {127'd0, outValid}, 128'd1);
    chk(outWrEn == (di != 0), {req, " wren R8"}, {127'd0, outWrEn}, {127'd0, di != 0});
    if (di != 0) chk(outRdIdx == di, {req, " dest R8"}, {123'd0, outRdIdx}, {123'd0, di});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    chk(!outValid && !outWrEn && outData == '0 && outRdIdx == '0, "R11 reset",
        {outValid, outWrEn, outData[125:0]}, '0);
  endtask

  task automatic testIlvLow();
    runOp("R1 byte", 4'd0, 5'd3, 5'd4, 5'd7, PA, PB);
    runOp("R1 half", 4'd1, 5'd3, 5'd4, 5'd7, PA, PB);
    runOp("R1 word", 4'd2, 5'd3, 5'd4, 5'd9, PB, PA);
  endtask

  task automatic testOthers();
    runOp("R2 upper word", 4'd3, 5'd1, 5'd2, 5'd5, PA, PB);
    runOp("R3 pack", 4'd4, 5'd1, 5'd2, 5'd5, PA, PB);
    runOp("R4 replicate", 4'd5, 5'd1, 5'd2, 5'd6, PA, PB);
    runOp("R5 copy low", 4'd6, 5'd1, 5'd2, 5'd6, PA, PB);
    runOp("R5 copy high", 4'd7, 5'd1, 5'd2, 5'd6, PA, PB);
    runOp("R6 rotate", 4'd8, 5'd1, 5'd2, 5'd31, PA, PB);
  endtask

  task automatic testZeroIdx();
    runOp("R7 zero rs", 4'd6, 5'd0, 5'd2, 5'd4, PA, PB);
    runOp("R7 zero rt", 4'd8, 5'd1, 5'd0, 5'd4, PA, PB);
    runOp("R8 null dest", 4'd2, 5'd1, 5'd2, 5'd0, PA, PB);
  endtask

  task automatic testUnknown();
    runOp("R10 op9", 4'd9, 5'd1, 5'd2, 5'd3, PA, PB);
    runOp("R10 op15", 4'd15, 5'd1, 5'd2, 5'd3, PA, PB);
  endtask

  task automatic testIdle();
    @(posedge clk); #1;
    chk(!outValid && !outWrEn, "R9 idle", {126'd0, outValid, outWrEn}, '0);
  endtask

  initial begin : watchdog
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testIlvLow();
    testOthers();
    testZeroIdx();
    testUnknown();
    testIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule